// File: doc/BRIEF.md
# Handshake Ordering Monitor

This block is a synthesizable runtime checker for the handshake between a data translator and the node that receives its output. Four signals from the design under test feed the checker directly: a transaction-close strobe, a transaction-open strobe, a link-fault strobe and a translator-ready level. The checker only observes them. It evaluates two ordering rules on every clock cycle and reports any breach.

The first rule covers the gap between transactions. After every transaction close, the next transaction must open before any link fault appears. The second rule says the translator must not signal ready before the first transaction has opened.

Each rule is built by wiring together small operator primitives: a continuous-scope tracker, an implication gate, a one-cycle delay and an ordering checker. Every primitive has its own enable and result ports. Each rule has three outputs:
- a pending flag, for an open obligation;
- a single-cycle fail pulse, in the cycle of the breach;
- a sticky fail flag, which holds until reset.

An obligation that is still open when observation stops is not a failure. It shows only on the pending flag.

Top module: `proto_mon`

## Requirements
- R1: During and right after the synchronous reset `rst`: both fail pulses are 0, both sticky flags are 0, `ord_pend_o` is 0, and `rdy_pend_o` is 1.
- R2: A close strobe in cycle t opens an obligation. `ord_pend_o` is 1 in cycle t+1. A fault in cycle t itself does not breach that new obligation.
- R3: A fault while an obligation is open and no open strobe has come gives `ord_fail_o` = 1 in that same cycle. The obligation then closes, so `ord_pend_o` is 0 in the next cycle unless a new close strobe arrived.
- R4: An open strobe while an obligation is open discharges it. `ord_pend_o` drops in the next cycle, and later faults give no fail pulse.
- R5: The ordering is strict. An open strobe and a fault in the same cycle while an obligation is open give `ord_fail_o` = 1.
- R6: Every close strobe opens an obligation, including those after earlier ones have been discharged or failed. A close strobe while an obligation is already open merges with it, so a single fault gives one fail pulse and not two.
- R7: Until the first open strobe after reset, every cycle with ready high and no open strobe gives `rdy_fail_o` = 1. Ready in the same cycle as the first open strobe, or in any later cycle, gives no pulse.
- R8: `rdy_pend_o` stays 1 until the first open strobe after reset. From the next cycle on it stays 0 until reset.
- R9: Each fail pulse sets that rule's sticky flag, which is 1 from the next cycle on. The flag is cleared only by reset.
- R10: An obligation that stays open with no fault never produces a fail pulse. It shows only as `ord_pend_o` = 1.
- R11: A fault while no obligation is open has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txn_close_i | input | 1 | Transaction-close strobe from the design under test |
| txn_open_i | input | 1 | Transaction-open strobe from the design under test |
| link_fault_i | input | 1 | Link-fault strobe from the design under test |
| xlat_rdy_i | input | 1 | Translator-ready level from the design under test |
| ord_pend_o | output | 1 | Close-to-open obligation open in this cycle |
| ord_fail_o | output | 1 | Close-to-open rule breached in this cycle |
| ord_sticky_o | output | 1 | Close-to-open rule breached since reset |
| rdy_pend_o | output | 1 | No open strobe seen since reset |
| rdy_fail_o | output | 1 | Ready-before-open rule breached in this cycle |
| rdy_sticky_o | output | 1 | Ready-before-open rule breached since reset |

## Verification
The assertions assume that the monitored strobes hold steady within a cycle and stay low while reset is held. The stimulus keeps to this: the bench drives every input just after the rising edge and forces all four to zero during each reset.

Past values of the close strobe are only trusted when the previous cycle was out of reset. This is because the delay stage is cleared during reset.

Beyond the directed sequences, the random phase weights faults above opens. This makes close-then-fault breaches, same-cycle open-and-fault clashes and merged closes all occur many times.

// File: rtl/proto_mon_pkg.sv
package proto_mon_pkg;

    // Ordering primitive: is an obligation open?
    typedef enum logic {
        OBL_IDLE = 1'b0,
        OBL_WAIT = 1'b1
    } obl_state_e;

    // Continuous-scope primitive: breach history
    typedef enum logic {
        TRK_CLEAN   = 1'b0,
        TRK_TRIPPED = 1'b1
    } trk_state_e;

    // Delay primitive: trigger carried to the next cycle
    typedef enum logic {
        NXT_QUIET = 1'b0,
        NXT_ARMED = 1'b1
    } nxt_state_e;

endpackage

// File: rtl/mon_op_always.sv
module mon_op_always
    import proto_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fail_i,
    output logic en_o,
    output logic sticky_o
);

    trk_state_e state_q;
    trk_state_e state_d;

    // Scope is active in every cycle outside reset
    assign en_o = ~rst;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_CLEAN:   if (fail_i) state_d = TRK_TRIPPED;
            TRK_TRIPPED: state_d = TRK_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TRK_CLEAN;
        else     state_q <= state_d;
    end

    always_comb begin
        sticky_o = (state_q == TRK_TRIPPED);
    end

endmodule

// File: rtl/mon_op_implies.sv
module mon_op_implies (
    input  logic en_i,
    input  logic ante_i,
    output logic trig_o
);

    assign trig_o = en_i & ante_i;

endmodule

// File: rtl/mon_op_next.sv
module mon_op_next
    import proto_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic arm_o
);

    nxt_state_e state_q;
    nxt_state_e state_d;

    always_comb begin
        state_d = NXT_QUIET;
        unique case (state_q)
            NXT_QUIET: if (trig_i) state_d = NXT_ARMED;
            NXT_ARMED: if (trig_i) state_d = NXT_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= NXT_QUIET;
        else     state_q <= state_d;
    end

    always_comb begin
        arm_o = (state_q == NXT_ARMED);
    end

endmodule

// File: rtl/mon_op_before.sv
module mon_op_before
    import proto_mon_pkg::*;
#(
    parameter bit STRICT    = 1'b1,  // same-cycle clash counts as a breach
    parameter bit HOLD_FAIL = 1'b0,  // obligation survives its own breach
    parameter bit INIT_OPEN = 1'b0   // obligation open straight out of reset
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic arm_i,
    input  logic first_i,   // event that must come first
    input  logic second_i,  // event that must not come first
    output logic pend_o,
    output logic fail_o
);

    localparam obl_state_e RST_STATE = INIT_OPEN ? OBL_WAIT : OBL_IDLE;

    obl_state_e state_q;
    obl_state_e state_d;
    logic       active;
    logic       breach;
    logic       clash_ok;

    generate
        if (STRICT) begin : g_strict
            assign clash_ok = 1'b0;
        end else begin : g_loose
            assign clash_ok = first_i;
        end
    endgenerate

    always_comb begin
        active = (state_q == OBL_WAIT) | arm_i;
        breach = en_i & active & second_i & ~clash_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OBL_IDLE: begin
                if (arm_i) begin
                    if (breach)       state_d = HOLD_FAIL ? OBL_WAIT : OBL_IDLE;
                    else if (first_i) state_d = OBL_IDLE;
                    else              state_d = OBL_WAIT;
                end
            end
            OBL_WAIT: begin
                if (breach)       state_d = HOLD_FAIL ? OBL_WAIT : OBL_IDLE;
                else if (first_i) state_d = OBL_IDLE;
                else              state_d = OBL_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RST_STATE;
        else     state_q <= state_d;
    end

    always_comb begin
        pend_o = active;
        fail_o = breach;
    end

endmodule

// File: rtl/proto_mon.sv
module proto_mon #(
    parameter bit ORD_STRICT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic txn_close_i,
    input  logic txn_open_i,
    input  logic link_fault_i,
    input  logic xlat_rdy_i,
    output logic ord_pend_o,
    output logic ord_fail_o,
    output logic ord_sticky_o,
    output logic rdy_pend_o,
    output logic rdy_fail_o,
    output logic rdy_sticky_o
);

    // Rule 1: always (close -> next (open before fault))
    logic ord_en;
    logic ord_trig;
    logic ord_arm;

    mon_op_always u_ord_always (
        .clk      (clk),
        .rst      (rst),
        .fail_i   (ord_fail_o),
        .en_o     (ord_en),
        .sticky_o (ord_sticky_o)
    );

    mon_op_implies u_ord_implies (
        .en_i   (ord_en),
        .ante_i (txn_close_i),
        .trig_o (ord_trig)
    );

    mon_op_next u_ord_next (
        .clk    (clk),
        .rst    (rst),
        .trig_i (ord_trig),
        .arm_o  (ord_arm)
    );

    mon_op_before #(
        .STRICT    (ORD_STRICT),
        .HOLD_FAIL (1'b0),
        .INIT_OPEN (1'b0)
    ) u_ord_before (
        .clk      (clk),
        .rst      (rst),
        .en_i     (ord_en),
        .arm_i    (ord_arm),
        .first_i  (txn_open_i),
        .second_i (link_fault_i),
        .pend_o   (ord_pend_o),
        .fail_o   (ord_fail_o)
    );

    // Rule 2: ready must not come before the first open
    logic rdy_en;

    mon_op_always u_rdy_always (
        .clk      (clk),
        .rst      (rst),
        .fail_i   (rdy_fail_o),
        .en_o     (rdy_en),
        .sticky_o (rdy_sticky_o)
    );

    mon_op_before #(
        .STRICT    (1'b0),
        .HOLD_FAIL (1'b1),
        .INIT_OPEN (1'b1)
    ) u_rdy_before (
        .clk      (clk),
        .rst      (rst),
        .en_i     (rdy_en),
        .arm_i    (1'b0),
        .first_i  (txn_open_i),
        .second_i (xlat_rdy_i),
        .pend_o   (rdy_pend_o),
        .fail_o   (rdy_fail_o)
    );

endmodule

// File: rtl/proto_mon_chk.sv
module proto_mon_chk (
    input logic clk,
    input logic rst,
    input logic txn_close_i,
    input logic txn_open_i,
    input logic link_fault_i,
    input logic xlat_rdy_i,
    input logic ord_pend_o,
    input logic ord_fail_o,
    input logic ord_sticky_o,
    input logic rdy_pend_o,
    input logic rdy_fail_o,
    input logic rdy_sticky_o
);

    a_r2_close_opens: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(txn_close_i)) |-> ord_pend_o);

    a_r3_fail_needs_fault: assert property (@(posedge clk) disable iff (rst)
        ord_fail_o |-> (link_fault_i && ord_pend_o));

    a_r5_clash_fails: assert property (@(posedge clk) disable iff (rst)
        (ord_pend_o && txn_open_i && link_fault_i) |-> ord_fail_o);

    a_r7_rdy_fail_cause: assert property (@(posedge clk) disable iff (rst)
        rdy_fail_o |-> (rdy_pend_o && xlat_rdy_i && !txn_open_i));

    a_r8_rdy_pend_stays_low: assert property (@(posedge clk) disable iff (rst)
        !rdy_pend_o |=> !rdy_pend_o);

    a_r9_ord_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        ord_fail_o |=> ord_sticky_o);

    a_r9_ord_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        ord_sticky_o |=> ord_sticky_o);

    a_r9_rdy_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        rdy_fail_o |=> rdy_sticky_o);

    a_r9_rdy_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        rdy_sticky_o |=> rdy_sticky_o);

endmodule

bind proto_mon proto_mon_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .txn_close_i  (txn_close_i),
    .txn_open_i   (txn_open_i),
    .link_fault_i (link_fault_i),
    .xlat_rdy_i   (xlat_rdy_i),
    .ord_pend_o   (ord_pend_o),
    .ord_fail_o   (ord_fail_o),
    .ord_sticky_o (ord_sticky_o),
    .rdy_pend_o   (rdy_pend_o),
    .rdy_fail_o   (rdy_fail_o),
    .rdy_sticky_o (rdy_sticky_o)
);

// File: tb/sim_proto_mon.sv
`timescale 1ns/1ps
module sim_proto_mon;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic close_s = 1'b0, open_s = 1'b0, fault_s = 1'b0, rdy_s = 1'b0;
    logic ord_pend, ord_fail, ord_sticky, rdy_pend, rdy_fail, rdy_sticky;

    int total = 0;
    int bad   = 0;

    // Behavioural reference state
    bit m_arm, m_wait, m_seen, m_st1, m_st2;

    always #4 clk = ~clk;

    proto_mon u0 (
        .clk          (clk),
        .rst          (rst),
        .txn_close_i  (close_s),
        .txn_open_i   (open_s),
        .link_fault_i (fault_s),
        .xlat_rdy_i   (rdy_s),
        .ord_pend_o   (ord_pend),
        .ord_fail_o   (ord_fail),
        .ord_sticky_o (ord_sticky),
        .rdy_pend_o   (rdy_pend),
        .rdy_fail_o   (rdy_fail),
        .rdy_sticky_o (rdy_sticky)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, got, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; close_s = 0; open_s = 0; fault_s = 0; rdy_s = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_arm = 0; m_wait = 0; m_seen = 0; m_st1 = 0; m_st2 = 0;
        @(negedge clk);
        chk("R1 ord_pend", ord_pend, 1'b0);
        chk("R1 ord_fail", ord_fail, 1'b0);
        chk("R1 ord_sticky", ord_sticky, 1'b0);
        chk("R1 rdy_pend", rdy_pend, 1'b1);
        chk("R1 rdy_fail", rdy_fail, 1'b0);
        chk("R1 rdy_sticky", rdy_sticky, 1'b0);
    endtask

    // One cycle: drive after the edge, compare with the model before the next
    task automatic step(input bit e, input bit s, input bit er, input bit r);
        bit act, f1, f2;
        @(posedge clk); #1;
        close_s = e; open_s = s; fault_s = er; rdy_s = r;
        @(negedge clk);
        act = m_wait | m_arm;
        f1  = act & er;
        f2  = !m_seen & r & !s;
        chk("R2 ord_pend", ord_pend, act);
        chk("R3 ord_fail", ord_fail, f1);
        chk("R8 rdy_pend", rdy_pend, !m_seen);
        chk("R7 rdy_fail", rdy_fail, f2);
        chk("R9 ord_sticky", ord_sticky, m_st1);
        chk("R9 rdy_sticky", rdy_sticky, m_st2);
        m_wait = act & !er & !s;
        m_arm  = e;
        m_seen = m_seen | s;
        m_st1  = m_st1 | f1;
        m_st2  = m_st2 | f2;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // Ready before the first open
        step(0, 0, 0, 1); chk("R7 early ready", rdy_fail, 1'b1);
        step(0, 0, 0, 1); chk("R7 repeated early ready", rdy_fail, 1'b1);
        step(0, 0, 0, 0); chk("R9 rdy sticky set", rdy_sticky, 1'b1);
        chk("R8 still waiting", rdy_pend, 1'b1);
        step(0, 1, 0, 1); chk("R7 ready with open", rdy_fail, 1'b0);
        step(0, 0, 0, 1); chk("R7 ready after open", rdy_fail, 1'b0);
        chk("R8 open seen", rdy_pend, 1'b0);

        // Fault with nothing open
        step(0, 0, 1, 0); chk("R11 stray fault", ord_fail, 1'b0);
        step(0, 0, 0, 0); chk("R11 no sticky", ord_sticky, 1'b0);
        chk("R11 nothing pending", ord_pend, 1'b0);

        // Close and fault in the same cycle, then fault later
        step(1, 0, 1, 0); chk("R2 same-cycle fault", ord_fail, 1'b0);
        step(0, 0, 0, 0); chk("R2 pending after close", ord_pend, 1'b1);
        step(0, 0, 1, 0); chk("R3 fault breaches", ord_fail, 1'b1);
        step(0, 0, 0, 0); chk("R3 closed after breach", ord_pend, 1'b0);
        chk("R9 ord sticky set", ord_sticky, 1'b1);

        // Open discharges
        step(1, 0, 0, 0);
        step(0, 1, 0, 0); chk("R4 open no fail", ord_fail, 1'b0);
        step(0, 0, 1, 0); chk("R4 later fault ignored", ord_fail, 1'b0);
        chk("R4 discharged", ord_pend, 1'b0);

        // Strict ordering clash
        step(1, 0, 0, 0);
        step(0, 1, 1, 0); chk("R5 clash fails", ord_fail, 1'b1);

        // Merged closes: one breach only
        step(1, 0, 0, 0);
        step(1, 0, 0, 0); chk("R6 merged pending", ord_pend, 1'b1);
        step(0, 0, 1, 0); chk("R6 first fault", ord_fail, 1'b1);
        step(0, 0, 1, 0); chk("R6 no second breach", ord_fail, 1'b0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0); chk("R6 reopened", ord_pend, 1'b1);

        // Open obligation left hanging
        step(0, 0, 0, 0); chk("R10 hanging no fail", ord_fail, 1'b0);
        step(0, 0, 0, 0); chk("R10 still pending", ord_pend, 1'b1);

        // Reset clears history
        do_reset();

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 6) == 0, ($urandom % 7) == 0,
                 ($urandom % 4) == 0, ($urandom % 5) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule